// File: doc/BRIEF.md
# Inter-Processor Signal Interrupt Controller

This block collects numbered doorbell signals that other processors raise toward the local processor and presents them as one active-high level interrupt. Every signal is named by a packed identifier: the client number sits in bits 31:16 and the signal number in bits 15:0. Remote agents raise signals through a flat pulse vector, and the local processor can send a signal to any client through the send register. When loopback is on, a sent signal is also marked pending locally, so software can test the interrupt path without a second processor.

Software works through a small 32-bit register port. It masks, unmasks and clears one signal by writing its packed identifier to the matching register. It clears all signals of one client with a single write. It finds the most urgent pending and enabled signal by reading the receive-identifier register. That register can be set to clear the reported signal on read, which lets a handler drain all pending signals with reads alone.

Top module: `sigctl_top`

## Requirements
- R1: After reset, the configuration register reads 0, the receive-identifier register (0x10) reads 0xFFFFFFFF and `irq` is low. Reads of any unmapped address return 0.
- R2: Reading 0x10 returns {client[15:0], signal[15:0]} for the highest-priority signal that is both pending and enabled, or 0xFFFFFFFF if there is none. A lower client number always wins. Within one client, a lower signal number wins.
- R3: A one-cycle pulse on `rx_raise` bit client*N_SIGNALS+signal makes that signal pending whether or not it is enabled.
- R4: Writing an identifier to 0x14 enables that one signal, and writing it to 0x18 disables it. Disabling a signal hides it from 0x10 and from `irq` but keeps it pending, so enabling it again makes it visible again.
- R5: `irq` is high exactly while at least one signal is both pending and enabled.
- R6: Writing an identifier to 0x1C clears only that signal's pending bit. If a raise of the same signal arrives in the same cycle, the raise wins and the signal stays pending.
- R7: Writing a client number (in bits 15:0) to 0x38 clears every pending signal of that client.
- R8: Configuration register 0x08 bit 0 turns on clear-on-read. With it set, a read of 0x10 clears the reported signal, and the next read reports the next signal by priority. With it clear, reads do not change any state.
- R9: Writing an identifier to 0x0C makes `tx_valid` high for exactly the next cycle, with `tx_id` equal to the written identifier. If configuration bit 1 (loopback) is set, the signal also becomes pending locally.
- R10: A write of an identifier whose client is not below N_CLIENTS or whose signal is not below N_SIGNALS has no effect on send, enable, disable or clear. A client-clear write with a client number out of range also has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| rx_raise | input | N_CLIENTS*N_SIGNALS | Raise pulses from remote agents, one bit per signal |
| irq | output | 1 | Level interrupt to the local processor |
| tx_valid | output | 1 | One-cycle pulse when a signal is sent |
| tx_id | output | 32 | Packed identifier of the sent signal |

## Verification
The bound checker watches several rules on every cycle. Whenever 0x10 is addressed, the all-ones value must agree with a low `irq`, and any other value must name a client and signal inside the configured range. `tx_valid` may only follow a write to the send register. A signal that was just disabled must not be reported in the next cycle. Other behaviours only show up in the bench's sequences: the order of priority between clients and within one client, pending state that survives masking, draining in priority order under clear-on-read, the loopback path, client-wide clear, a raise beating a clear in the same cycle, and identifiers out of range that must not alias into the valid range.

// File: rtl/sigctl_pkg.sv
package sigctl_pkg;
   localparam logic [7:0] OFS_CFG   = 8'h08;
   localparam logic [7:0] OFS_SEND  = 8'h0C;
   localparam logic [7:0] OFS_RECV  = 8'h10;
   localparam logic [7:0] OFS_EN    = 8'h14;
   localparam logic [7:0] OFS_DIS   = 8'h18;
   localparam logic [7:0] OFS_CLR   = 8'h1C;
   localparam logic [7:0] OFS_CCLR  = 8'h38;

   localparam int CFG_BITS = 2;
   localparam int CFG_COR  = 0;
   localparam int CFG_LOOP = 1;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_CFG,
      OP_SEND,
      OP_EN,
      OP_DIS,
      OP_CLR,
      OP_CCLR
   } wr_op_e;
endpackage

// File: rtl/sigctl_decode.sv
module sigctl_decode
   import sigctl_pkg::*;
#(
   parameter int N_CLIENTS = 4,
   parameter int N_SIGNALS = 8,
   parameter int ADDR_W    = 8,
   localparam int TOTAL    = N_CLIENTS * N_SIGNALS,
   localparam int IDX_W    = (TOTAL > 1) ? $clog2(TOTAL) : 1,
   localparam int CLI_W    = (N_CLIENTS > 1) ? $clog2(N_CLIENTS) : 1
)(
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [31:0]       bus_wdata,
   output wr_op_e            op,
   output logic              id_ok,
   output logic [IDX_W-1:0]  id_idx,
   output logic              cli_ok,
   output logic [CLI_W-1:0]  cli_num,
   output logic              recv_rd
);
   logic [15:0] cli_field;
   logic [15:0] sig_field;

   assign cli_field = bus_wdata[31:16];
   assign sig_field = bus_wdata[15:0];

   assign id_ok   = (32'(cli_field) < N_CLIENTS) && (32'(sig_field) < N_SIGNALS);
   assign id_idx  = IDX_W'(32'(cli_field) * N_SIGNALS + 32'(sig_field));
   assign cli_ok  = 32'(sig_field) < N_CLIENTS;
   assign cli_num = CLI_W'(sig_field);
   assign recv_rd = bus_rd && (bus_addr == ADDR_W'(OFS_RECV));

   always_comb begin
      op = OP_NONE;
      if (bus_wr) begin
         case (bus_addr)
            ADDR_W'(OFS_CFG):  op = OP_CFG;
            ADDR_W'(OFS_SEND): op = OP_SEND;
            ADDR_W'(OFS_EN):   op = OP_EN;
            ADDR_W'(OFS_DIS):  op = OP_DIS;
            ADDR_W'(OFS_CLR):  op = OP_CLR;
            ADDR_W'(OFS_CCLR): op = OP_CCLR;
            default:           op = OP_NONE;
         endcase
      end
   end
endmodule

// File: rtl/sigctl_bank.sv
module sigctl_bank #(
   parameter int TOTAL    = 32,
   parameter bit SET_WINS = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TOTAL-1:0] pend_set,
   input  logic [TOTAL-1:0] pend_clr,
   input  logic [TOTAL-1:0] en_set,
   input  logic [TOTAL-1:0] en_clr,
   output logic [TOTAL-1:0] pend,
   output logic [TOTAL-1:0] en
);
   for (genvar b = 0; b < TOTAL; b++) begin : g_bit
      if (SET_WINS) begin : g_set_wins
         always_ff @(posedge clk) begin
            if (!rst_n) pend[b] <= 1'b0;
            else        pend[b] <= (pend[b] & ~pend_clr[b]) | pend_set[b];
         end
      end else begin : g_clr_wins
         always_ff @(posedge clk) begin
            if (!rst_n) pend[b] <= 1'b0;
            else        pend[b] <= (pend[b] | pend_set[b]) & ~pend_clr[b];
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) en[b] <= 1'b0;
         else        en[b] <= en_set[b] | (en[b] & ~en_clr[b]);
      end
   end
endmodule

// File: rtl/sigctl_prio.sv
module sigctl_prio #(
   parameter int TOTAL = 32,
   localparam int IDX_W = (TOTAL > 1) ? $clog2(TOTAL) : 1
)(
   input  logic [TOTAL-1:0] req,
   output logic             any,
   output logic [IDX_W-1:0] win
);
   always_comb begin
      any = 1'b0;
      win = '0;
      for (int i = TOTAL - 1; i >= 0; i--) begin
         if (req[i]) begin
            any = 1'b1;
            win = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/sigctl_top.sv
module sigctl_top
   import sigctl_pkg::*;
#(
   parameter int N_CLIENTS = 4,
   parameter int N_SIGNALS = 8,
   parameter int ADDR_W    = 8,
   parameter bit SET_WINS  = 1'b1,
   localparam int TOTAL    = N_CLIENTS * N_SIGNALS,
   localparam int IDX_W    = (TOTAL > 1) ? $clog2(TOTAL) : 1,
   localparam int CLI_W    = (N_CLIENTS > 1) ? $clog2(N_CLIENTS) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [TOTAL-1:0]  rx_raise,
   output logic              irq,
   output logic              tx_valid,
   output logic [31:0]       tx_id
);
   if (N_CLIENTS < 1 || N_CLIENTS > 65535) begin : g_bad_clients
      $error("sigctl_top: N_CLIENTS out of range");
   end
   if (N_SIGNALS < 1 || N_SIGNALS > 65535) begin : g_bad_signals
      $error("sigctl_top: N_SIGNALS out of range");
   end
   if (TOTAL > 4096) begin : g_bad_total
      $error("sigctl_top: too many signals");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("sigctl_top: ADDR_W must be at least 8");
   end

   wr_op_e               op;
   logic                 id_ok;
   logic [IDX_W-1:0]     id_idx;
   logic                 cli_ok;
   logic [CLI_W-1:0]     cli_num;
   logic                 recv_rd;
   logic [CFG_BITS-1:0]  cfg_q;
   logic [TOTAL-1:0]     id_hot;
   logic [TOTAL-1:0]     cli_mask;
   logic [TOTAL-1:0]     cor_hot;
   logic [TOTAL-1:0]     pend_set;
   logic [TOTAL-1:0]     pend_clr;
   logic [TOTAL-1:0]     en_set;
   logic [TOTAL-1:0]     en_clr;
   logic [TOTAL-1:0]     pend;
   logic [TOTAL-1:0]     en;
   logic                 any;
   logic [IDX_W-1:0]     win;
   logic [31:0]          recv_val;

   sigctl_decode #(
      .N_CLIENTS (N_CLIENTS),
      .N_SIGNALS (N_SIGNALS),
      .ADDR_W    (ADDR_W)
   ) i_decode (
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .op        (op),
      .id_ok     (id_ok),
      .id_idx    (id_idx),
      .cli_ok    (cli_ok),
      .cli_num   (cli_num),
      .recv_rd   (recv_rd)
   );

   assign id_hot = id_ok ? (TOTAL'(1) << id_idx) : '0;

   for (genvar c = 0; c < N_CLIENTS; c++) begin : g_cli
      assign cli_mask[c*N_SIGNALS +: N_SIGNALS] =
         (cli_ok && cli_num == CLI_W'(c)) ? '1 : '0;
   end

   assign cor_hot  = (recv_rd && cfg_q[CFG_COR] && any) ? (TOTAL'(1) << win) : '0;
   assign pend_set = rx_raise | ((op == OP_SEND && cfg_q[CFG_LOOP]) ? id_hot : '0);
   assign pend_clr = ((op == OP_CLR)  ? id_hot   : '0)
                   | ((op == OP_CCLR) ? cli_mask : '0)
                   | cor_hot;
   assign en_set   = (op == OP_EN)  ? id_hot : '0;
   assign en_clr   = (op == OP_DIS) ? id_hot : '0;

   sigctl_bank #(
      .TOTAL    (TOTAL),
      .SET_WINS (SET_WINS)
   ) i_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .pend_set (pend_set),
      .pend_clr (pend_clr),
      .en_set   (en_set),
      .en_clr   (en_clr),
      .pend     (pend),
      .en       (en)
   );

   sigctl_prio #(
      .TOTAL (TOTAL)
   ) i_prio (
      .req (pend & en),
      .any (any),
      .win (win)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q    <= '0;
         tx_valid <= 1'b0;
         tx_id    <= '0;
      end else begin
         if (op == OP_CFG) cfg_q <= bus_wdata[CFG_BITS-1:0];
         tx_valid <= (op == OP_SEND) && id_ok;
         if (op == OP_SEND && id_ok) tx_id <= bus_wdata;
      end
   end

   assign recv_val = any ? {16'(32'(win) / N_SIGNALS), 16'(32'(win) % N_SIGNALS)} : '1;
   assign irq      = any;

   always_comb begin
      case (bus_addr)
         ADDR_W'(OFS_CFG):  bus_rdata = 32'(cfg_q);
         ADDR_W'(OFS_RECV): bus_rdata = recv_val;
         default:           bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/sigctl_chk.sv
module sigctl_chk
   import sigctl_pkg::*;
#(
   parameter int N_CLIENTS = 4,
   parameter int N_SIGNALS = 8,
   parameter int ADDR_W    = 8
)(
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic              irq,
   input logic              tx_valid
);
   // R1
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !irq);

   // R2
   idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(OFS_RECV)) |-> ((bus_rdata == 32'hFFFF_FFFF) == !irq));

   // R2
   id_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(OFS_RECV) && bus_rdata != 32'hFFFF_FFFF) |->
      (32'(bus_rdata[31:16]) < N_CLIENTS && 32'(bus_rdata[15:0]) < N_SIGNALS));

   // R9
   tx_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> $past(bus_wr && bus_addr == ADDR_W'(OFS_SEND)));

   // R4
   mask_hides_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFS_DIS)) |=>
      !(bus_addr == ADDR_W'(OFS_RECV) && bus_rdata == $past(bus_wdata)));
endmodule

bind sigctl_top sigctl_chk #(
   .N_CLIENTS (N_CLIENTS),
   .N_SIGNALS (N_SIGNALS),
   .ADDR_W    (ADDR_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .irq       (irq),
   .tx_valid  (tx_valid)
);

// File: tb/test_sigctl_top.sv
module test_sigctl_top;
   localparam int NC = 4;
   localparam int NS = 8;
   localparam int TOT = NC * NS;
   localparam logic [7:0] A_CFG = 8'h08, A_SEND = 8'h0C, A_RECV = 8'h10,
                          A_EN = 8'h14, A_DIS = 8'h18, A_CLR = 8'h1C, A_CCLR = 8'h38;
   localparam logic [31:0] NONE = 32'hFFFF_FFFF;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [7:0]     bus_addr = '0;
   logic           bus_wr = 1'b0;
   logic           bus_rd = 1'b0;
   logic [31:0]    bus_wdata = '0;
   logic [31:0]    bus_rdata;
   logic [TOT-1:0] rx_raise = '0;
   logic           irq;
   logic           tx_valid;
   logic [31:0]    tx_id;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #5 clk = ~clk;

   sigctl_top #(.N_CLIENTS(NC), .N_SIGNALS(NS), .ADDR_W(8)) i_sigctl_top (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_raise(rx_raise),
      .irq(irq), .tx_valid(tx_valid), .tx_id(tx_id));

   function automatic logic [31:0] sid(int c, int s);
      return {16'(c), 16'(s)};
   endfunction

   task automatic compare(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: pops one expected item per read strobe
   always @(negedge clk) begin
      #3;
      if (bus_rd) begin
         if (exp_q.size() == 0) compare("monitor underflow", 32'h0, 32'h1);
         else compare(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
   end

   task automatic idle();
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0; rx_raise = '0;
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0; rx_raise = '0;
   endtask

   task automatic wr_raise(logic [7:0] a, logic [31:0] d, int idx);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
      rx_raise = '0; rx_raise[idx] = 1'b1;
   endtask

   task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
      @(negedge clk);
      bus_addr = a; bus_wr = 1'b0; bus_rd = 1'b1; rx_raise = '0;
      exp_q.push_back(exp); tag_q.push_back(tag);
   endtask

   task automatic raise(int idx);
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0; rx_raise = '0; rx_raise[idx] = 1'b1;
   endtask

   task automatic chk_irq(logic e, string tag);
      idle();
      #3;
      compare(tag, 32'(irq), 32'(e));
   endtask

   task automatic chk_tx(logic v, logic [31:0] id, string tag);
      idle();
      #3;
      compare({tag, " valid"}, 32'(tx_valid), 32'(v));
      if (v) compare({tag, " id"}, tx_id, id);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(A_CFG, 32'h0, "R1 cfg after reset");
      rd(A_RECV, NONE, "R1 recv after reset");
      rd(8'h20, 32'h0, "R1 unmapped read");
      chk_irq(1'b0, "R1 irq after reset");

      // R3 raise while masked, R4 enable reveals it
      raise(2*NS + 5);
      rd(A_RECV, NONE, "R3 masked pending hidden");
      chk_irq(1'b0, "R5 irq low while masked");
      wr(A_EN, sid(2,5));
      rd(A_RECV, sid(2,5), "R3 pending kept while masked");
      chk_irq(1'b1, "R5 irq high");

      // R2 priority across and within clients
      raise(1*NS + 7);
      wr(A_EN, sid(1,7));
      rd(A_RECV, sid(1,7), "R2 lower client wins");
      raise(1*NS + 3);
      wr(A_EN, sid(1,3));
      rd(A_RECV, sid(1,3), "R2 lower signal wins");
      rd(A_RECV, sid(1,3), "R8 no clear without cfg bit");

      // R4 disable keeps pending
      wr(A_DIS, sid(1,3));
      rd(A_RECV, sid(1,7), "R4 disabled hidden");
      wr(A_EN, sid(1,3));
      rd(A_RECV, sid(1,3), "R4 re-enable shows pending");

      // R6 single clear
      wr(A_CLR, sid(1,3));
      rd(A_RECV, sid(1,7), "R6 only target cleared");

      // R8 clear on read drains in priority order
      wr(A_CFG, 32'h1);
      rd(A_CFG, 32'h1, "R8 cfg readback");
      rd(A_RECV, sid(1,7), "R8 first read");
      rd(A_RECV, sid(2,5), "R8 second read");
      rd(A_RECV, NONE, "R8 drained");
      chk_irq(1'b0, "R8 irq after drain");

      // R9 send without and with loopback
      wr(A_CFG, 32'h0);
      wr(A_SEND, sid(3,2));
      chk_tx(1'b1, sid(3,2), "R9 send pulse");
      chk_tx(1'b0, '0, "R9 pulse one cycle");
      wr(A_EN, sid(3,2));
      rd(A_RECV, NONE, "R9 no loopback when off");
      wr(A_CFG, 32'h2);
      wr(A_SEND, sid(3,2));
      chk_tx(1'b1, sid(3,2), "R9 send pulse loop");
      rd(A_RECV, sid(3,2), "R9 loopback pending");

      // R7 client clear
      raise(3*NS + 0);
      raise(3*NS + 1);
      wr(A_EN, sid(3,0));
      wr(A_EN, sid(3,1));
      rd(A_RECV, sid(3,0), "R7 before client clear");
      wr(A_CCLR, 32'd3);
      rd(A_RECV, NONE, "R7 client cleared");
      wr(A_EN, sid(3,1));
      rd(A_RECV, NONE, "R7 all signals of client cleared");

      // R10 out-of-range identifiers must not alias
      raise(3);
      wr(A_EN, sid(0,3));
      rd(A_RECV, sid(0,3), "R10 setup");
      wr(A_CLR, 32'h0010_0003);
      rd(A_RECV, sid(0,3), "R10 clear out of range client");
      wr(A_CLR, 32'h0000_0013);
      rd(A_RECV, sid(0,3), "R10 clear out of range signal");
      wr(A_DIS, 32'h0004_0003);
      rd(A_RECV, sid(0,3), "R10 disable out of range");
      wr(A_CCLR, 32'd4);
      rd(A_RECV, sid(0,3), "R10 client clear out of range");
      wr(A_SEND, 32'h0000_0008);
      chk_tx(1'b0, '0, "R10 send out of range");

      // R6 raise beats clear in the same cycle
      wr_raise(A_CLR, sid(0,3), 3);
      rd(A_RECV, sid(0,3), "R6 raise wins over clear");
      wr(A_CLR, sid(0,3));
      rd(A_RECV, NONE, "R6 clear applied");
      chk_irq(1'b0, "R5 irq low at end");

      idle();
      idle();
      if (exp_q.size() != 0) compare("monitor leftover", 32'(exp_q.size()), 32'h0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule